// File: doc/BRIEF.md
# Buffered Word Program Sequencer

This block runs a multi-step buffered program command in front of a small word-addressed storage array. A host issues bus write cycles. The first cycle carries an opening code, and its address selects the destination block. The second cycle carries a count n. The next n+1 cycles each carry one address and data word, which the block places in an internal staging buffer. A final cycle carries a commit code. The block checks every step as it arrives. If any step breaks the rules, it raises an error flag in its status byte and drops the whole command, and the array keeps its previous contents.

When the commit code is accepted and the destination block is not locked, the sequencer becomes busy. It then steps through the staging buffer in ascending address order and spends a fixed number of clock cycles on each slot of the window. Each word that was loaded is written into the array. While this runs, the ready bit of the status byte reads 0 and bus writes are dropped. When the last slot is done, the ready bit returns to 1 and a one-cycle completion pulse is raised. The status byte can be read at any time. The array contents can be read through a separate read port, so the host can see the result of a command.

Top module: `wbprog_seq`

## Requirements
- R1: After reset, `status` reads 0x80, `busy` and `done` are 0, and every array word reads all ones (0xFFFF).
- R2: A write whose low data byte is 0xE8, made while the sequencer is idle, opens a command and clears status bits 4 and 1. Any other write made while idle is ignored and leaves the status and the array unchanged.
- R3: The count write must target the same block as the opening write, where the block is `bus_addr[7:6]`. Its value n must be below 32. Otherwise status bit 4 is set, the command is dropped and the array is unchanged.
- R4: The first load address becomes the start address. Every load address must lie in the command's block and inside the window from start to start+n. A load outside this window sets status bit 4, drops the command and leaves the array unchanged.
- R5: Exactly n+1 load writes are taken. If a load address repeats, the later data replaces the earlier data for that address.
- R6: The write that follows the loads must carry 0xD0 in its low byte and target the command's block. Any other write in that position sets status bit 4 and drops the command without an array change.
- R7: If `lock_blk` is set for the command's block when the 0xD0 write arrives, status bits 4 and 1 are both set, the sequencer never becomes busy, and the array is unchanged.
- R8: An accepted commit makes `busy` high for exactly (n+1)*PROG_CYC cycles, and status bit 7 reads 0 during that time. After it, every loaded word reads back at its own address, status bit 7 is 1, and `done` is high for one cycle as `busy` falls.
- R9: Bus writes made while `busy` is high are ignored. They neither lengthen the commit nor change any stored word.
- R10: An address inside the window that received no load keeps its previous array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 8 | Bus write address |
| bus_wdata | input | 16 | Bus write data or command code (low byte) |
| lock_blk | input | 4 | Per-block protection, bit i locks block i |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 16 | Array word at `rd_addr` |
| status | output | 8 | Bit 7 ready, bit 4 command failed, bit 1 block locked |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle pulse at commit completion |

## Verification
The assertions check on every cycle that array writes happen only while busy, that the staging buffer is never written during a commit, that every staged slot index lies inside the declared window, that a commit only starts with clean error bits, and that the completion pulse is one cycle wide and coincides with the fall of busy. The sequence and address rules, the exact commit length, overwrites by repeated addresses, untouched gaps in the window, and the lock abort depend on the values the host sends. Only the bench's scenarios can show these, by reading back status and array words after each command.

// File: rtl/wbp_pkg.sv
// Package: shared phase type, command codes and status bit positions for
// the buffered program sequencer. Assumes command codes sit in the low byte.
package wbp_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_COUNT,
        PH_LOAD,
        PH_CONFIRM,
        PH_COMMIT
    } wbp_phase_e;

    localparam logic [7:0] CODE_OPEN   = 8'hE8;
    localparam logic [7:0] CODE_COMMIT = 8'hD0;

    localparam int ST_READY = 7;
    localparam int ST_FAIL  = 4;
    localparam int ST_LOCK  = 1;
endpackage

// File: rtl/wbp_window_chk.sv
// Window checker: decides whether a load address lies in the command's
// block and inside [start, start+n], and returns its slot index.
// Assumes: before the first load, the address itself becomes the start.
module wbp_window_chk #(
    parameter int AW    = 8,
    parameter int BLK_W = 6,
    parameter int IW    = 5
) (
    input  logic [AW-1:0]       addr,
    input  logic [AW-BLK_W-1:0] blk,
    input  logic [AW-1:0]       start,
    input  logic                have_start,
    input  logic [IW-1:0]       n,
    output logic                in_blk,
    output logic                in_win,
    output logic [IW-1:0]       idx
);
    logic [AW-1:0] base;
    logic [AW-1:0] off;

    // Compute block match, offset from the window base and window membership.
    always_comb begin
        base   = have_start ? start : addr;
        off    = addr - base;
        in_blk = (addr[AW-1:BLK_W] == blk);
        in_win = in_blk && (addr >= base) && (off <= AW'(n));
        idx    = off[IW-1:0];
    end
endmodule

// File: rtl/wbp_buffer.sv
// Staging buffer: DEPTH data words, each with a valid flag. Clear drops all
// the valid flags in one cycle. Assumes one write port and one read port.
module wbp_buffer #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    parameter int IW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] vld;

    // Store a data word into its slot.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    // Track which slots hold loaded data.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) vld <= '0;
        else if (we)       vld[widx] <= 1'b1;
    end

    // Read the slot selected for commit.
    always_comb begin
        rdata  = mem[ridx];
        rvalid = vld[ridx];
    end
endmodule

// File: rtl/wbp_array.sv
// Storage array: 2**AW words that reset to all ones, with one write port
// and one asynchronous read port. Assumes a small AW (a register file).
module wbp_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;
    logic [DW-1:0] cells [WORDS];

    // Set every word to the erased value on reset, otherwise apply writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '1;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Drive the read port.
    assign rdata = cells[raddr];
endmodule

// File: rtl/wbprog_seq.sv
// Top: buffered program sequencer. It decodes the open, count, load and
// commit bus writes, checks the block, window and code rules, checks the
// lock, and then commits the staged words in address order over PROG_CYC
// cycles per slot. Assumes DW >= 8 and a buffer no larger than one block.
module wbprog_seq
    import wbp_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int BLK_W     = 6,
    parameter int BUF_DEPTH = 32,
    parameter int PROG_CYC  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [AW-1:0]              bus_addr,
    input  logic [DW-1:0]              bus_wdata,
    input  logic [(1<<(AW-BLK_W))-1:0] lock_blk,
    input  logic [AW-1:0]              rd_addr,
    output logic [DW-1:0]              rd_data,
    output logic [7:0]                 status,
    output logic                       busy,
    output logic                       done
);
    localparam int NBLK = 1 << (AW - BLK_W);
    localparam int BW   = AW - BLK_W;
    localparam int IW   = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
    localparam int CW   = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;
    localparam logic [CW-1:0] LAST_TICK = CW'(PROG_CYC - 1);

    wbp_phase_e    phase;
    logic [BW-1:0] blk_q;
    logic [IW-1:0] n_q;
    logic [IW:0]   left_q;
    logic [AW-1:0] start_q;
    logic          have_start_q;
    logic          err_fail_q;
    logic          err_lock_q;
    logic [IW-1:0] idx_q;
    logic [CW-1:0] tick_q;
    logic          done_q;

    logic          win_in_blk;
    logic          win_ok;
    logic [IW-1:0] win_idx;
    logic          buf_we;
    logic [IW-1:0] buf_widx;
    logic          buf_clr;
    logic [DW-1:0] buf_rdata;
    logic          buf_rvalid;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic          slot_end;
    logic          same_blk;
    logic          code_open;
    logic          code_commit;
    logic          count_ok;

    wbp_window_chk #(.AW(AW), .BLK_W(BLK_W), .IW(IW)) u_win (
        .addr       (bus_addr),
        .blk        (blk_q),
        .start      (start_q),
        .have_start (have_start_q),
        .n          (n_q),
        .in_blk     (win_in_blk),
        .in_win     (win_ok),
        .idx        (win_idx)
    );

    wbp_buffer #(.DEPTH(BUF_DEPTH), .DW(DW), .IW(IW)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (buf_clr),
        .we     (buf_we),
        .widx   (buf_widx),
        .wdata  (bus_wdata),
        .ridx   (idx_q),
        .rdata  (buf_rdata),
        .rvalid (buf_rvalid)
    );

    wbp_array #(.AW(AW), .DW(DW)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (buf_rdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // Decode the current bus write against the command codes and rules.
    always_comb begin
        same_blk    = (bus_addr[AW-1:BLK_W] == blk_q);
        code_open   = (bus_wdata[7:0] == CODE_OPEN);
        code_commit = (bus_wdata[7:0] == CODE_COMMIT);
        count_ok    = same_blk && (bus_wdata < DW'(BUF_DEPTH));
        buf_we      = bus_we && (phase == PH_LOAD) && win_ok;
        buf_widx    = win_idx;
        buf_clr     = bus_we && (phase == PH_IDLE) && code_open;
        slot_end    = (phase == PH_COMMIT) && (tick_q == LAST_TICK);
        arr_we      = slot_end && buf_rvalid;
        arr_waddr   = start_q + AW'(idx_q);
    end

    // Phase sequencing, rule checks, error flags and the commit walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_IDLE;
            blk_q        <= '0;
            n_q          <= '0;
            left_q       <= '0;
            start_q      <= '0;
            have_start_q <= 1'b0;
            err_fail_q   <= 1'b0;
            err_lock_q   <= 1'b0;
            idx_q        <= '0;
            tick_q       <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (bus_we && code_open) begin
                        phase        <= PH_COUNT;
                        blk_q        <= bus_addr[AW-1:BLK_W];
                        have_start_q <= 1'b0;
                        err_fail_q   <= 1'b0;
                        err_lock_q   <= 1'b0;
                    end
                end
                PH_COUNT: begin
                    if (bus_we) begin
                        if (count_ok) begin
                            phase  <= PH_LOAD;
                            n_q    <= bus_wdata[IW-1:0];
                            left_q <= {1'b0, bus_wdata[IW-1:0]} + 1'b1;
                        end else begin
                            phase      <= PH_IDLE;
                            err_fail_q <= 1'b1;
                        end
                    end
                end
                PH_LOAD: begin
                    if (bus_we) begin
                        if (win_ok) begin
                            if (!have_start_q) begin
                                start_q      <= bus_addr;
                                have_start_q <= 1'b1;
                            end
                            left_q <= left_q - 1'b1;
                            if (left_q == 1) phase <= PH_CONFIRM;
                        end else begin
                            phase      <= PH_IDLE;
                            err_fail_q <= 1'b1;
                        end
                    end
                end
                PH_CONFIRM: begin
                    if (bus_we) begin
                        if (!(code_commit && same_blk)) begin
                            phase      <= PH_IDLE;
                            err_fail_q <= 1'b1;
                        end else if (lock_blk[blk_q]) begin
                            phase      <= PH_IDLE;
                            err_fail_q <= 1'b1;
                            err_lock_q <= 1'b1;
                        end else begin
                            phase  <= PH_COMMIT;
                            idx_q  <= '0;
                            tick_q <= '0;
                        end
                    end
                end
                PH_COMMIT: begin
                    if (slot_end) begin
                        tick_q <= '0;
                        if (idx_q == n_q) begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Present the status byte and the handshake outputs.
    always_comb begin
        busy             = (phase == PH_COMMIT);
        done             = done_q;
        status           = '0;
        status[ST_READY] = !busy;
        status[ST_FAIL]  = err_fail_q;
        status[ST_LOCK]  = err_lock_q;
    end

    logic unused_blk;
    assign unused_blk = win_in_blk ^ (NBLK == 0);
endmodule

// File: rtl/wbp_seq_checker.sv
// Checker: cycle-by-cycle properties of the buffered program sequencer.
// It is attached to every wbprog_seq instance by the bind below.
module wbp_seq_checker #(
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [7:0]    status,
    input logic          arr_we,
    input logic          buf_we,
    input logic [IW-1:0] buf_widx,
    input logic [IW-1:0] n_q
);
    // R7 (also R3, R4, R6): the array is written only during a commit.
    assert_array_write_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R9: the staging buffer stays still while a commit runs.
    assert_buffer_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we);

    // R4: a staged slot index never exceeds the declared count.
    assert_slot_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_widx <= n_q));

    // R6: a commit starts only with clear error flags.
    assert_clean_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (status[4] == 1'b0 && status[1] == 1'b0));

    // R8: the completion pulse lasts one cycle and coincides with the fall of busy.
    assert_done_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

bind wbprog_seq wbp_seq_checker #(.IW(IW)) u_wbp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .status   (status),
    .arr_we   (arr_we),
    .buf_we   (buf_we),
    .buf_widx (buf_widx),
    .n_q      (n_q)
);

// File: tb/wbprog_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for wbprog_seq: one task per scenario, each checking itself.
module wbprog_seq_bench;
    localparam int PC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [3:0]  lock_blk = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  status;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;

    wbprog_seq #(.PROG_CYC(PC)) u_wbprog_seq (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .lock_blk(lock_blk), .rd_addr(rd_addr),
        .rd_data(rd_data), .status(status), .busy(busy), .done(done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, input logic [15:0] exp, input string req);
        rd_addr = a;
        #0.1;
        chk(rd_data == exp, req, rd_data, exp);
    endtask

    // Wait for the commit to end. Return the number of busy cycles and
    // whether done was seen when busy fell.
    task automatic wait_commit(output int cyc, output bit saw_done);
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
        saw_done = done;
    endtask

    task automatic t_reset();
        chk(status == 8'h80, "R1 status", status, 8'h80);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        peek(8'h00, 16'hFFFF, "R1 array 00");
        peek(8'hFF, 16'hFFFF, "R1 array FF");
    endtask

    task automatic t_idle_ignore();
        bus_write(8'h10, 16'h00D0);
        bus_write(8'h11, 16'h1234);
        chk(status == 8'h80, "R2 idle write status", status, 8'h80);
        chk(busy == 1'b0, "R2 idle write busy", busy, 0);
        peek(8'h10, 16'hFFFF, "R2 idle write array");
    endtask

    task automatic t_basic_commit();
        int cyc; bit sd;
        bus_write(8'h45, 16'h00E8);
        bus_write(8'h40, 16'd3);
        bus_write(8'h48, 16'hA001);
        bus_write(8'h49, 16'hA002);
        bus_write(8'h4A, 16'hA003);
        bus_write(8'h4B, 16'hA004);
        bus_write(8'h40, 16'h00D0);
        chk(status[7] == 1'b0, "R8 ready low while busy", status, 8'h00);
        // R9: a write during the commit is dropped.
        bus_we = 1'b1; bus_addr = 8'h49; bus_wdata = 16'h00E8;
        @(negedge clk);
        bus_we = 1'b0;
        wait_commit(cyc, sd);
        cyc++;
        chk(cyc == 4*PC, "R8 R9 commit length", cyc, 4*PC);
        chk(sd, "R8 done pulse", sd, 1);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        chk(status == 8'h80, "R8 status after commit", status, 8'h80);
        peek(8'h48, 16'hA001, "R8 word 48");
        peek(8'h49, 16'hA002, "R8 R9 word 49");
        peek(8'h4B, 16'hA004, "R8 word 4B");
        peek(8'h4C, 16'hFFFF, "R8 outside window");
    endtask

    task automatic t_repeat_gap();
        int cyc; bit sd;
        bus_write(8'h80, 16'h00E8);
        bus_write(8'hBF, 16'd2);
        bus_write(8'h90, 16'h1111);
        bus_write(8'h92, 16'h2222);
        bus_write(8'h90, 16'h3333);
        bus_write(8'h85, 16'h00D0);
        wait_commit(cyc, sd);
        chk(cyc == 3*PC, "R8 commit length n=2", cyc, 3*PC);
        peek(8'h90, 16'h3333, "R5 repeated address");
        peek(8'h92, 16'h2222, "R5 second word");
        peek(8'h91, 16'hFFFF, "R10 gap unchanged");
    endtask

    task automatic t_count_errors();
        bus_write(8'h00, 16'h00E8);
        bus_write(8'h00, 16'd32);
        chk(status == 8'h90, "R3 count too large", status, 8'h90);
        bus_write(8'h00, 16'h00E8);
        chk(status == 8'h80, "R2 open clears error", status, 8'h80);
        bus_write(8'h40, 16'd1);
        chk(status == 8'h90, "R3 count in other block", status, 8'h90);
        // R3: the following data and commit writes are ignored after the abort.
        bus_write(8'h00, 16'h5555);
        bus_write(8'h00, 16'h00D0);
        chk(busy == 1'b0, "R3 no commit after abort", busy, 0);
        peek(8'h00, 16'hFFFF, "R3 array unchanged");
    endtask

    task automatic t_window_errors();
        bus_write(8'hC0, 16'h00E8);
        bus_write(8'hC0, 16'd1);
        bus_write(8'hC4, 16'h7777);
        bus_write(8'hC6, 16'h8888);
        chk(status == 8'h90, "R4 above window", status, 8'h90);
        peek(8'hC4, 16'hFFFF, "R4 array unchanged above");
        bus_write(8'hC0, 16'h00E8);
        bus_write(8'hC0, 16'd3);
        bus_write(8'hC4, 16'h7777);
        bus_write(8'hC3, 16'h8888);
        chk(status == 8'h90, "R4 below start", status, 8'h90);
        bus_write(8'hC0, 16'h00E8);
        bus_write(8'hC0, 16'd3);
        bus_write(8'h04, 16'h7777);
        chk(status == 8'h90, "R4 other block", status, 8'h90);
        peek(8'hC3, 16'hFFFF, "R4 array unchanged below");
    endtask

    task automatic t_confirm_error();
        bus_write(8'h20, 16'h00E8);
        bus_write(8'h20, 16'd0);
        bus_write(8'h21, 16'h4444);
        bus_write(8'h20, 16'h00AA);
        chk(status == 8'h90, "R6 wrong commit code", status, 8'h90);
        chk(busy == 1'b0, "R6 not busy", busy, 0);
        peek(8'h21, 16'hFFFF, "R6 array unchanged");
    endtask

    task automatic t_locked();
        lock_blk = 4'b1000;
        bus_write(8'hC0, 16'h00E8);
        bus_write(8'hC0, 16'd0);
        bus_write(8'hD0, 16'h6666);
        bus_write(8'hC0, 16'h00D0);
        chk(status == 8'h92, "R7 locked block", status, 8'h92);
        chk(busy == 1'b0, "R7 not busy", busy, 0);
        peek(8'hD0, 16'hFFFF, "R7 array unchanged");
        lock_blk = 4'b0000;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_basic_commit();
        t_repeat_gap();
        t_count_errors();
        t_window_errors();
        t_confirm_error();
        t_locked();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule